// File: doc/BRIEF.md
# Vectored Interrupt Merger with DMA Status

This block folds the interrupt requests of a video raster source and three DMA channels into one vectored interrupt that suits a mode-2 style acknowledge cycle. A cause register records who interrupted last. Code 6 stands for the raster source and is also the idle state. Code 2c stands for DMA channel c. While the feature set is unlocked, the byte offered on `ack_vector` takes its upper five bits from a programmable vector register and its low three bits from the cause. While the feature set is locked, the byte is all ones.

A single-cycle register write port reaches two registers. `wr_sel` = 0 selects the vector register and `wr_sel` = 1 selects the DMA status register. The status register byte has this layout:

- bit 7: the last acknowledge was taken for the raster source.
- bits 6, 5 and 4: pending flags for channels 0, 1 and 2.
- bit 3: always 0.
- bits 2 to 0: enables for channels 2, 1 and 0.

Writing a 1 to a flag position clears that flag. Writing a 0 to a flag position does nothing. Bit 0 of the vector register is also brought out as a DMA-clear control bit. The DMA sequencers and the raster counter sit outside this block. They only pulse `ch_event` and `ack`.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `dma_status` is 0x00, `ch_enable` is 0, `dma_clear` is 1 and `ack_vector` is 0x06 (vector register 0x01, cause 6).
- R2: A write with `wr_sel`=0 stores `wr_data` in the vector register. From the next cycle, bits 7..3 of the stored byte appear in `ack_vector[7:3]` and bit 0 drives `dma_clear`.
- R3: While `locked` is 0, `ack_vector` equals {vector[7:3], cause[2:0]}.
- R4: While `locked` is 1, `ack_vector` is 0xFF. An `ack` pulse taken while locked leaves `dma_status` bit 7 unchanged.
- R5: A pulse on `ch_event[c]` sets the cause to 2c and sets `dma_status[6-c]` in the next cycle. When several channels fire in the same cycle, the highest channel index sets the cause.
- R6: An `ack` pulse taken while unlocked sets `dma_status[7]` if the cause is 6 and clears it otherwise. The flags and enables stay unchanged.
- R7: A write with `wr_sel`=1 copies `wr_data[2:0]` into `ch_enable` and `dma_status[2:0]`. Written values in bits 7 and 3, and zeros in bits 6..4, have no effect. Bit 3 always reads 0.
- R8: In a write with `wr_sel`=1, a 1 in `wr_data[6-c]` clears the flag of channel c. If no channel event arrives in that cycle, the cause returns to 6.
- R9: If `ch_event[c]` and a write that clears the flag of channel c come in the same cycle, the flag stays set and the cause becomes 2c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 vector, 1 DMA status |
| wr_data | input | 8 | Write data |
| ch_event | input | 3 | Per-channel DMA interrupt pulses |
| ack | input | 1 | Interrupt acknowledge strobe |
| locked | input | 1 | Feature set locked |
| ack_vector | output | 8 | Byte returned during acknowledge |
| dma_status | output | 8 | DMA control/status byte |
| ch_enable | output | 3 | DMA channel enables |
| dma_clear | output | 1 | DMA-clear control (vector bit 0) |

## Verification
The bench fires two channels in one cycle. A design that ranked the channels the other way would report cause 0 instead of 4. It writes zeros and stray ones into the flag positions and bit 3 of the status register: a design that stored them plainly would drop pending flags or expose bit 3. It acknowledges while locked, which a design that ignored the lock would let rewrite bit 7 and leak the real vector. It also lands a clearing write in the same cycle as a fresh event on that channel; a design that let the write win would lose the interrupt and report cause 6.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned CAUSE_W = 3;
   localparam int unsigned NUM_CH  = 3;
   localparam logic [CAUSE_W-1:0] RASTER_CAUSE = 3'd6;
   localparam logic [BYTE_W-1:0]  VEC_RESET    = 8'h01;
   localparam logic [BYTE_W-1:0]  LOCKED_BYTE  = 8'hFF;
   // Status byte layout
   localparam int unsigned RASTER_BIT = 7;
   localparam int unsigned FLAG_TOP   = 6;   // channel c flag at FLAG_TOP - c
   localparam int unsigned SPARE_BIT  = 3;

   function automatic logic [CAUSE_W-1:0] ch_cause(input int unsigned c);
      return CAUSE_W'(c * 2);
   endfunction
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
   import vec_irq_pkg::*;
#(
   parameter int unsigned N_CH = NUM_CH,
   parameter int unsigned C_W  = CAUSE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_event,
   input  logic            flag_ack,
   output logic [C_W-1:0]  cause
);
   logic [C_W-1:0] cause_nxt;

   always_comb begin
      cause_nxt = cause;
      if (flag_ack) cause_nxt = C_W'(RASTER_CAUSE);
      // later channels override earlier ones: highest index wins
      for (int unsigned c = 0; c < N_CH; c++) begin
         if (ch_event[c]) cause_nxt = C_W'(ch_cause(c));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause <= C_W'(RASTER_CAUSE);
      else        cause <= cause_nxt;
   end

   // R8
   ack_to_raster_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ack && (ch_event == '0)) |=> (cause == C_W'(RASTER_CAUSE)));
   // R5
   top_ch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_event[N_CH-1] |=> (cause == C_W'((N_CH-1) * 2)));
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
   import vec_irq_pkg::*;
#(
   parameter int unsigned B_W = BYTE_W,
   parameter int unsigned C_W = CAUSE_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [B_W-1:0] wr_data,
   output logic [B_W-1:0] vec_q,
   output logic           clear_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vec_q <= B_W'(VEC_RESET);
      else if (wr) vec_q <= wr_data;
   end

   assign clear_bit = vec_q[0];

   // R2
   clear_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (clear_bit == $past(wr_data[0])));
   // R2
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(vec_q));
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg
   import vec_irq_pkg::*;
#(
   parameter int unsigned N_CH = NUM_CH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [N_CH-1:0] wr_enables,
   input  logic [N_CH-1:0] wr_clear,     // indexed by channel
   input  logic [N_CH-1:0] ch_event,
   input  logic            ack_take,     // acknowledge while unlocked
   input  logic            ack_raster,   // current cause is the raster code
   output logic [N_CH-1:0] enables,
   output logic [N_CH-1:0] flags,        // indexed by channel
   output logic            raster_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  enables <= '0;
      else if (wr) enables <= wr_enables;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        raster_last <= 1'b0;
      else if (ack_take) raster_last <= ack_raster;
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     flags[c] <= 1'b0;
         else if (ch_event[c])           flags[c] <= 1'b1;
         else if (wr && wr_clear[c])     flags[c] <= 1'b0;
      end

      // R5 R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_event[c] |=> flags[c]);
      // R7
      flag_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_event[c] && !(wr && wr_clear[c])) |=> (flags[c] == $past(flags[c])));
   end

   // R6
   raster_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && ack_raster) |=> raster_last);
   // R4
   raster_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_take |=> $stable(raster_last));
   // R7
   enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (enables == $past(wr_enables)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vec_irq_pkg::*;
#(
   parameter int unsigned N_CH = NUM_CH,
   parameter int unsigned B_W  = BYTE_W,
   parameter int unsigned C_W  = CAUSE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [B_W-1:0]  wr_data,
   input  logic [N_CH-1:0] ch_event,
   input  logic            ack,
   input  logic            locked,
   output logic [B_W-1:0]  ack_vector,
   output logic [B_W-1:0]  dma_status,
   output logic [N_CH-1:0] ch_enable,
   output logic            dma_clear
);
   localparam int unsigned VEC_HI_W = B_W - C_W;

   if (N_CH != 3) begin : g_bad_ch
      $error("vec_irq_ctrl: status layout holds exactly three channels");
   end
   if (B_W != 8) begin : g_bad_bw
      $error("vec_irq_ctrl: byte width must be 8");
   end
   if (C_W != 3) begin : g_bad_cw
      $error("vec_irq_ctrl: cause width must be 3");
   end

   logic            wr_vec, wr_stat;
   logic [N_CH-1:0] wr_clear, flags;
   logic [C_W-1:0]  cause;
   logic [B_W-1:0]  vec_q;
   logic            raster_last, flag_ack;

   assign wr_vec  = wr_en && !wr_sel;
   assign wr_stat = wr_en &&  wr_sel;

   for (genvar c = 0; c < N_CH; c++) begin : g_map
      assign wr_clear[c]             = wr_data[FLAG_TOP - c];
      assign dma_status[FLAG_TOP - c] = flags[c];
   end
   assign dma_status[RASTER_BIT] = raster_last;
   assign dma_status[SPARE_BIT]  = 1'b0;
   assign dma_status[N_CH-1:0]   = ch_enable;

   assign flag_ack = wr_stat && (wr_clear != '0);

   irq_cause_reg #(.N_CH(N_CH), .C_W(C_W)) u_cause (
      .clk(clk), .rst_n(rst_n), .ch_event(ch_event),
      .flag_ack(flag_ack), .cause(cause)
   );

   irq_vector_reg #(.B_W(B_W), .C_W(C_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec), .wr_data(wr_data),
      .vec_q(vec_q), .clear_bit(dma_clear)
   );

   dma_status_reg #(.N_CH(N_CH)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr(wr_stat),
      .wr_enables(wr_data[N_CH-1:0]), .wr_clear(wr_clear),
      .ch_event(ch_event), .ack_take(ack && !locked),
      .ack_raster(cause == C_W'(RASTER_CAUSE)),
      .enables(ch_enable), .flags(flags), .raster_last(raster_last)
   );

   assign ack_vector = locked ? B_W'(LOCKED_BYTE)
                              : {vec_q[B_W-1 -: VEC_HI_W], cause};

   // R4
   locked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && locked) |=> (dma_status[RASTER_BIT] == $past(dma_status[RASTER_BIT])));
   // R6
   dma_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !locked && (ack_vector[C_W-1:0] != C_W'(RASTER_CAUSE)))
      |=> !dma_status[RASTER_BIT]);
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, ack = 1'b0, locked = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] ch_event = '0;
   logic [7:0] ack_vector, dma_status;
   logic [2:0] ch_enable;
   logic       dma_clear;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ch_event(ch_event), .ack(ack), .locked(locked),
      .ack_vector(ack_vector), .dma_status(dma_status),
      .ch_enable(ch_enable), .dma_clear(dma_clear)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   // inputs applied a quarter period after a rising edge, held for one edge
   task automatic step();
      @(posedge clk);
      #(CLK_PERIOD/4);
      wr_en = 1'b0; ack = 1'b0; ch_event = '0;
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
   endtask

   task automatic t_reset();
      chk("R1 status", dma_status, 8'h00);
      chk("R1 enable", {5'd0, ch_enable}, 8'h00);
      chk("R1 clear", {7'd0, dma_clear}, 8'h01);
      chk("R1 vector", ack_vector, 8'h06);
   endtask

   task automatic t_vector();
      wr_reg(1'b0, 8'hA5);
      chk("R2 R3 vector A5", ack_vector, 8'hA6);
      chk("R2 clear set", {7'd0, dma_clear}, 8'h01);
      wr_reg(1'b0, 8'h52);
      chk("R2 R3 vector 52", ack_vector, 8'h56);
      chk("R2 clear low", {7'd0, dma_clear}, 8'h00);
      chk("R2 status untouched", dma_status, 8'h00);
   endtask

   task automatic t_events();
      ch_event = 3'b010; step();
      chk("R5 cause ch1", ack_vector, 8'h52);
      chk("R5 flag ch1", dma_status, 8'h20);
      ack = 1'b1; step();
      chk("R6 dma ack bit7 low", dma_status, 8'h20);
      ch_event = 3'b101; step();
      chk("R5 multi cause", ack_vector, 8'h54);
      chk("R5 multi flags", dma_status, 8'h70);
   endtask

   task automatic t_status_wr();
      wr_reg(1'b1, 8'h05);
      chk("R7 enables", {5'd0, ch_enable}, 8'h05);
      chk("R7 zeros keep flags", dma_status, 8'h75);
      wr_reg(1'b1, 8'h8D);
      chk("R7 bit7 bit3 ignored", dma_status, 8'h75);
      wr_reg(1'b1, 8'h25);
      chk("R8 clear ch1", dma_status, 8'h55);
      chk("R8 cause raster", ack_vector, 8'h56);
      ack = 1'b1; step();
      chk("R6 raster ack", dma_status, 8'hD5);
      ch_event = 3'b001; step();
      chk("R5 cause ch0", ack_vector, 8'h50);
      ack = 1'b1; step();
      chk("R6 dma ack clears bit7", dma_status, 8'h55);
   endtask

   task automatic t_lock();
      wr_reg(1'b1, 8'h75);
      chk("R8 clear all", dma_status, 8'h05);
      ack = 1'b1; step();
      chk("R6 raster ack again", dma_status, 8'h85);
      locked = 1'b1;
      ch_event = 3'b100; step();
      chk("R4 locked vector", ack_vector, 8'hFF);
      ack = 1'b1; step();
      chk("R4 locked ack no effect", dma_status, 8'h95);
      locked = 1'b0; #1;
      chk("R3 unlocked vector", ack_vector, 8'h54);
      wr_reg(1'b1, 8'h15);
      chk("R8 flags cleared", dma_status, 8'h85);
   endtask

   task automatic t_collide();
      ch_event = 3'b010; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h25;
      step();
      chk("R9 flag survives", dma_status, 8'hA5);
      chk("R9 cause from event", ack_vector, 8'h52);
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + CLK_PERIOD/4);
      rst_n = 1'b1;
      step();
      t_reset();
      t_vector();
      t_events();
      t_status_wr();
      t_lock();
      t_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule